// File: doc/BRIEF.md
# Direct-Mapped Read/Write-Through Cache Controller

This block is a small direct-mapped cache that sits between a processor that addresses whole words and a slower backing memory. A 14-bit word address is split into a tag, a line index and a word offset. The cache has 16 lines of 8 words each, and each line keeps a stored tag and a valid flag. A read whose line is valid and holds the same tag is answered from the cache. Any other read stalls the processor. The cache then pulls the whole 8-word block out of backing memory, one word per handshake. It overwrites whatever the line held, marks the line valid and returns the requested word.

Writes always go straight through to backing memory. If the written address is already cached, the cached word is updated at the same time. A write miss does not allocate a line. Because every block has exactly one possible line, two blocks that share an index evict each other. An alternating stream of such addresses therefore misses on every reference.

The processor raises `cpu_req` with an address while `cpu_stall` is low. From the cycle after acceptance until the response, `cpu_stall` stays high. The answer comes as a one-cycle `cpu_rvalid` pulse, together with `cpu_rdata` and a `cpu_hit` flag.

Top module: `dm_cache_ctrl`

## Requirements
- R1: After reset every line is invalid: `cpu_stall`, `cpu_rvalid`, `mem_rd_valid` and `mem_wr_valid` are low, and the first read of any address reports `cpu_hit`=0.
- R2: Address bits [13:7] are the tag, [6:3] the line index and [2:0] the word offset. A read miss issues exactly 8 backing reads, to addresses {tag, index, 0} up to {tag, index, 7}, in ascending order.
- R3: After the last refill beat, the read returns the requested word from the new block with `cpu_hit`=0.
- R4: A read whose indexed line is valid and holds the address tag returns the cached word with `cpu_hit`=1 and issues no backing reads.
- R5: A block that maps to an occupied line evicts it. Reading 0x1AA, then 0x3AB, then 0x1AB, 0x3AB, 0x1AB gives a miss every time after the first.
- R6: Blocks with different line indices are held at the same time: each stays a hit after the other has been loaded.
- R7: `cpu_stall` is high from the cycle after a request is accepted up to and including the response cycle, and low otherwise. A request raised while `cpu_stall` is high is ignored.
- R8: A refill beat completes only in a cycle where `mem_rd_valid` and `mem_rd_ready` are both high. While ready is low the read address holds steady.
- R9: A write hit makes one backing write with the same address and data, and updates the cached word. A later read of that address hits and returns the new value.
- R10: A write miss makes one backing write and allocates no line. A later read of that address misses and returns the value now in backing memory.
- R11: `cpu_rvalid` is high for exactly one cycle per accepted request. For a write, `cpu_rdata` echoes the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Request strobe, taken when `cpu_stall` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 14 | Word address |
| cpu_wdata | input | 16 | Write data |
| cpu_stall | output | 1 | Busy; requests are ignored while high |
| cpu_rvalid | output | 1 | One-cycle response pulse |
| cpu_rdata | output | 16 | Read word, or the echoed write data |
| cpu_hit | output | 1 | Request found its block in the cache (valid with `cpu_rvalid`) |
| mem_rd_valid | output | 1 | Refill read request |
| mem_rd_addr | output | 14 | Refill read word address |
| mem_rd_ready | input | 1 | Backing memory supplies `mem_rd_data` this cycle |
| mem_rd_data | input | 16 | Refill data |
| mem_wr_valid | output | 1 | Write-through request |
| mem_wr_addr | output | 14 | Write-through address |
| mem_wr_data | output | 16 | Write-through data |
| mem_wr_ready | input | 1 | Backing memory accepts the write this cycle |

## Verification
A corrupted tag or valid flag shows up on the first later access to that line. Either `cpu_hit` comes back wrong, or a hit suddenly produces eight backing reads, or a miss produces none. Those effects are visible by the response pulse of that same access. A wrong word in the data array only shows when that exact word is read back as a hit. For that reason the stimulus rereads refilled and written words, checking each against a value the bench computes from the address. A refill sequencer that skips, repeats or reorders offsets is caught beat by beat on `mem_rd_addr`, well before the response.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache controller.
// Assumes: nothing beyond the encoding of the sequencer states.
package dmc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
// Tag and valid storage, one entry per line.
// Assumes: one read index and one write port; valid flags clear on reset,
// tag contents are don't-care until their valid flag is set.
module dmc_tag_store #(
    parameter int TAG_W = 7,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;

    // Valid flags: cleared on reset, set when a line is installed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    // Tag array write.
    always_ff @(posedge clk) begin
        if (wr_en)
            tag_q[wr_idx] <= wr_tag;
    end

    // Asynchronous lookup of the indexed line.
    always_comb begin
        rd_tag   = tag_q[rd_idx];
        rd_valid = vld_q[rd_idx];
    end
endmodule

// File: rtl/dmc_data_store.sv
// Word storage for all lines, addressed by {line index, word offset}.
// Assumes: one asynchronous read port and one write port; no reset needed.
module dmc_data_store #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 3
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [OFF_W-1:0]  rd_off,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int WORDS = 1 << (IDX_W + OFF_W);

    logic [DATA_W-1:0] mem_q [WORDS];

    // Single-word write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem_q[{wr_idx, wr_off}] <= wr_data;
    end

    // Asynchronous read of the selected word.
    assign rd_data = mem_q[{rd_idx, rd_off}];
endmodule

// File: rtl/dmc_seq.sv
// Request sequencer: accepts a request, refills a whole block on a read miss,
// writes through on a write, and issues a one-cycle response.
// Assumes: lookup_hit is valid for cpu_addr while idle; the line being refilled
// is not looked up until the refill is over.
module dmc_seq
    import dmc_pkg::*;
#(
    parameter int TAG_W  = 7,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              lookup_hit,
    input  logic [DATA_W-1:0] word_q,
    output logic [ADDR_W-1:0] sv_addr,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              tw_en,
    output logic              dw_en,
    output logic [OFF_W-1:0]  dw_off,
    output logic [DATA_W-1:0] dw_data,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam logic [OFF_W-1:0] LAST_BEAT = {OFF_W{1'b1}};

    dmc_state_e        state_q;
    logic [OFF_W-1:0]  beat_q;
    logic              sv_we;
    logic              sv_hit;
    logic [DATA_W-1:0] sv_wdata;
    logic              rd_beat;
    logic              wr_done;

    assign rd_beat = (state_q == ST_FILL)  && mem_rd_ready;
    assign wr_done = (state_q == ST_WRITE) && mem_wr_ready;

    // State, beat counter and captured request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            beat_q   <= '0;
            sv_addr  <= '0;
            sv_we    <= 1'b0;
            sv_hit   <= 1'b0;
            sv_wdata <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (cpu_req) begin
                    sv_addr  <= cpu_addr;
                    sv_we    <= cpu_we;
                    sv_wdata <= cpu_wdata;
                    sv_hit   <= lookup_hit;
                    beat_q   <= '0;
                    if (cpu_we)          state_q <= ST_WRITE;
                    else if (lookup_hit) state_q <= ST_RESP;
                    else                 state_q <= ST_FILL;
                end
                ST_FILL: if (mem_rd_ready) begin
                    beat_q <= beat_q + 1'b1;
                    if (beat_q == LAST_BEAT) state_q <= ST_RESP;
                end
                ST_WRITE: if (mem_wr_ready) state_q <= ST_RESP;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Backing memory requests.
    always_comb begin
        mem_rd_valid = (state_q == ST_FILL);
        mem_rd_addr  = {sv_addr[ADDR_W-1:OFF_W], beat_q};
        mem_wr_valid = (state_q == ST_WRITE);
        mem_wr_addr  = sv_addr;
        mem_wr_data  = sv_wdata;
    end

    // Array update controls: refill beats, and write hits.
    always_comb begin
        tw_en   = rd_beat && (beat_q == LAST_BEAT);
        dw_en   = rd_beat || (wr_done && sv_hit);
        dw_off  = rd_beat ? beat_q : sv_addr[OFF_W-1:0];
        dw_data = rd_beat ? mem_rd_data : sv_wdata;
    end

    // Processor-side outputs.
    always_comb begin
        cpu_stall  = (state_q != ST_IDLE);
        cpu_rvalid = (state_q == ST_RESP);
        cpu_hit    = (state_q == ST_RESP) && sv_hit;
        cpu_rdata  = sv_we ? sv_wdata : word_q;
    end
endmodule

// File: rtl/dm_cache_ctrl.sv
// Top: direct-mapped cache with whole-block refill and write-through.
// Assumes: backing memory answers reads with mem_rd_ready and accepts
// writes with mem_wr_ready; only one request is outstanding at a time.
module dm_cache_ctrl #(
    parameter int TAG_W  = 7,
    parameter int IDX_W  = 4,
    parameter int OFF_W  = 3,
    parameter int DATA_W = 16,
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_stall,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_hit,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int IDX_LSB = OFF_W;
    localparam int TAG_LSB = OFF_W + IDX_W;

    logic [TAG_W-1:0]  line_tag;
    logic              line_vld;
    logic              lookup_hit;
    logic [ADDR_W-1:0] sv_addr;
    logic [DATA_W-1:0] word_q;
    logic              tw_en;
    logic              dw_en;
    logic [OFF_W-1:0]  dw_off;
    logic [DATA_W-1:0] dw_data;

    // Hit when the indexed line is valid and carries the request tag.
    assign lookup_hit = line_vld && (line_tag == cpu_addr[ADDR_W-1:TAG_LSB]);

    dmc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cpu_addr[TAG_LSB-1:IDX_LSB]),
        .rd_tag   (line_tag),
        .rd_valid (line_vld),
        .wr_en    (tw_en),
        .wr_idx   (sv_addr[TAG_LSB-1:IDX_LSB]),
        .wr_tag   (sv_addr[ADDR_W-1:TAG_LSB])
    );

    dmc_data_store #(.DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_data (
        .clk     (clk),
        .rd_idx  (sv_addr[TAG_LSB-1:IDX_LSB]),
        .rd_off  (sv_addr[OFF_W-1:0]),
        .rd_data (word_q),
        .wr_en   (dw_en),
        .wr_idx  (sv_addr[TAG_LSB-1:IDX_LSB]),
        .wr_off  (dw_off),
        .wr_data (dw_data)
    );

    dmc_seq #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .lookup_hit   (lookup_hit),
        .word_q       (word_q),
        .sv_addr      (sv_addr),
        .cpu_stall    (cpu_stall),
        .cpu_rvalid   (cpu_rvalid),
        .cpu_rdata    (cpu_rdata),
        .cpu_hit      (cpu_hit),
        .tw_en        (tw_en),
        .dw_en        (dw_en),
        .dw_off       (dw_off),
        .dw_data      (dw_data),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_ready (mem_rd_ready),
        .mem_rd_data  (mem_rd_data),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .mem_wr_ready (mem_wr_ready)
    );
endmodule

// File: rtl/dmc_checker.sv
// Protocol checks on the cache ports, bound into dm_cache_ctrl.
// Assumes: synchronous active-low reset shared with the design.
module dmc_checker #(
    parameter int ADDR_W = 14,
    parameter int OFF_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stall,
    input logic              cpu_rvalid,
    input logic              cpu_hit,
    input logic              mem_rd_valid,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rd_ready,
    input logic              mem_wr_valid,
    input logic [ADDR_W-1:0] mem_wr_addr,
    input logic              mem_wr_ready
);
    AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid); // R11

    AST_RESP_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> cpu_stall); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_stall |-> (!mem_rd_valid && !mem_wr_valid && !cpu_rvalid)); // R7

    AST_HIT_WITH_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> cpu_rvalid); // R4

    AST_BEAT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready && (mem_rd_addr[OFF_W-1:0] != {OFF_W{1'b1}}))
        |=> (mem_rd_valid &&
             mem_rd_addr[OFF_W-1:0] == OFF_W'($past(mem_rd_addr[OFF_W-1:0]) + 1'b1) &&
             mem_rd_addr[ADDR_W-1:OFF_W] == $past(mem_rd_addr[ADDR_W-1:OFF_W]))); // R2

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr))); // R8

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr))); // R9

    AST_LAST_BEAT_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && mem_rd_ready && (mem_rd_addr[OFF_W-1:0] == {OFF_W{1'b1}}))
        |=> (cpu_rvalid && !cpu_hit)); // R3
endmodule

bind dm_cache_ctrl dmc_checker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_stall    (cpu_stall),
    .cpu_rvalid   (cpu_rvalid),
    .cpu_hit      (cpu_hit),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_ready (mem_rd_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_ready (mem_wr_ready)
);

// File: tb/dm_cache_ctrl_bench.sv
// Self-checking bench: vector table of accesses, then directed tests.
module dm_cache_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [13:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_stall, cpu_rvalid, cpu_hit;
    logic [15:0] cpu_rdata;
    logic        mem_rd_valid, mem_wr_valid;
    logic [13:0] mem_rd_addr, mem_wr_addr;
    logic [15:0] mem_wr_data;
    logic        mem_rd_ready = 1'b0;
    logic [15:0] mem_rd_data = '0;
    logic        mem_wr_ready = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    // Backing memory model: fixed pattern plus a few recorded writes.
    logic [13:0] ov_addr [8];
    logic [15:0] ov_data [8];
    int          ov_n = 0;
    logic        slow = 1'b0;
    logic        tgl = 1'b0;
    int          beats = 0;
    int          wr_cnt = 0;
    logic        off_err = 1'b0;
    logic [13:0] tx_addr = '0;
    logic [13:0] wr_seen_addr = '0;
    logic [15:0] wr_seen_data = '0;

    dm_cache_ctrl u_dm_cache_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data),
        .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_ready(mem_wr_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [15:0] mem_word(input logic [13:0] a);
        logic [15:0] w;
        w = {2'b10, a} ^ 16'h0F0F;
        for (int i = 0; i < ov_n; i++)
            if (ov_addr[i] == a) w = ov_data[i];
        return w;
    endfunction

    // Memory side: drive ready/data at the falling edge and log handshakes.
    always @(negedge clk) begin
        tgl <= ~tgl;
        mem_rd_ready = slow ? tgl : 1'b1;
        mem_wr_ready = slow ? tgl : 1'b1;
        mem_rd_data  = mem_word(mem_rd_addr);
        if (mem_rd_valid && mem_rd_ready) begin
            if (mem_rd_addr != {tx_addr[13:3], 3'(beats)}) off_err = 1'b1;
            beats++;
        end
        if (mem_wr_valid && mem_wr_ready) begin
            wr_cnt++;
            wr_seen_addr = mem_wr_addr;
            wr_seen_data = mem_wr_data;
            if (ov_n < 8) begin
                ov_addr[ov_n] = mem_wr_addr;
                ov_data[ov_n] = mem_wr_data;
                ov_n++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", cycles, 100000);
            summary_and_end();
        end
    end

    // One access; optionally keeps a second request asserted during the stall.
    task automatic access(input bit we, input logic [13:0] a, input logic [15:0] wd,
                          input bit hold, input logic [13:0] hold_a,
                          output logic [15:0] rd, output bit hit, output bit stall_ok);
        int guard;
        stall_ok = 1'b1;
        @(negedge clk);
        while (cpu_stall) @(negedge clk);
        beats = 0; wr_cnt = 0; off_err = 1'b0; tx_addr = a;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk);
        if (hold) begin cpu_addr = hold_a; cpu_we = 1'b0; end
        else cpu_req = 1'b0;
        guard = 0;
        while (!cpu_rvalid && guard < 200) begin
            if (!cpu_stall) stall_ok = 1'b0;
            @(negedge clk);
            guard++;
        end
        rd = cpu_rdata;
        hit = cpu_hit;
        if (!cpu_stall) stall_ok = 1'b0;
        cpu_req = 1'b0;
        check(cpu_rvalid, "R11 response seen", 32'(cpu_rvalid), 32'd1);
    endtask

    // Vector: {we, addr, wdata, exp_hit, exp_beats, req_no}
    localparam logic [39:0] VEC [NV] = '{
        {1'b0, 14'h1AA, 16'h0000, 1'b0, 4'd8, 4'd1},  // R1 R2 R3 first read misses
        {1'b0, 14'h1AB, 16'h0000, 1'b1, 4'd0, 4'd4},  // R4 same block hits
        {1'b0, 14'h3AB, 16'h0000, 1'b0, 4'd8, 4'd5},  // R5 conflicting tag evicts
        {1'b0, 14'h1AB, 16'h0000, 1'b0, 4'd8, 4'd5},  // R5 thrash
        {1'b0, 14'h3AB, 16'h0000, 1'b0, 4'd8, 4'd5},  // R5 thrash
        {1'b0, 14'h055, 16'h0000, 1'b0, 4'd8, 4'd6},  // R6 other line
        {1'b0, 14'h1AB, 16'h0000, 1'b0, 4'd8, 4'd5},  // R5 thrash again
        {1'b0, 14'h050, 16'h0000, 1'b1, 4'd0, 4'd6},  // R6 other line kept
        {1'b1, 14'h1AC, 16'hBEEF, 1'b1, 4'd0, 4'd9},  // R9 write hit
        {1'b0, 14'h1AC, 16'h0000, 1'b1, 4'd0, 4'd9},  // R9 reads new word
        {1'b1, 14'h700, 16'h1234, 1'b0, 4'd0, 4'd10}, // R10 write miss
        {1'b0, 14'h700, 16'h0000, 1'b0, 4'd8, 4'd10}, // R10 no allocation
        {1'b0, 14'h707, 16'h0000, 1'b1, 4'd0, 4'd6}   // R6 block now present
    };

    initial begin
        logic [15:0] rd;
        bit hit, sok;
        repeat (3) @(negedge clk);
        // R1: reset state at the ports.
        check(!cpu_stall && !cpu_rvalid && !mem_rd_valid && !mem_wr_valid, "R1 reset outputs",
              {cpu_stall, cpu_rvalid, mem_rd_valid, mem_wr_valid}, 32'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic        we;
            logic [13:0] a;
            logic [15:0] wd, exp_d;
            logic        eh;
            logic [3:0]  eb, rn;
            string       tag;
            {we, a, wd, eh, eb, rn} = VEC[v];
            tag = $sformatf("R%0d vec%0d", rn, v);
            access(we, a, wd, 1'b0, '0, rd, hit, sok);
            exp_d = we ? wd : mem_word(a);
            check(rd == exp_d, {tag, " data"}, rd, exp_d);      // R3 R11
            check(hit == eh, {tag, " hit"}, hit, eh);
            check(beats == int'(eb), {tag, " beats"}, beats, eb); // R2
            check(!off_err, {tag, " R2 refill order"}, off_err, 0);
            check(sok, {tag, " R7 stall"}, sok, 1);
            check(wr_cnt == (we ? 1 : 0), {tag, " write count"}, wr_cnt, we);
            if (we) check(wr_seen_addr == a && wr_seen_data == wd, {tag, " write-through"},
                          {wr_seen_addr, wr_seen_data}, {a, wd});
        end

        // R8: refill with wait states on the backing memory.
        slow = 1'b1;
        access(1'b0, 14'h2F3, 16'h0, 1'b0, '0, rd, hit, sok);
        check(rd == mem_word(14'h2F3), "R8 data under wait states", rd, mem_word(14'h2F3));
        check(beats == 8 && !off_err, "R8 beats under wait states", beats, 8);
        slow = 1'b0;

        // R7: a request held during the stall is ignored.
        access(1'b0, 14'h0A0, 16'h0, 1'b1, 14'h123, rd, hit, sok);
        check(sok, "R7 stall held through refill", sok, 1);
        repeat (3) begin
            @(negedge clk);
            check(!cpu_rvalid && !cpu_stall && !mem_rd_valid, "R7 no extra response",
                  {cpu_rvalid, cpu_stall, mem_rd_valid}, 0);
        end
        access(1'b0, 14'h123, 16'h0, 1'b0, '0, rd, hit, sok);
        check(!hit && beats == 8, "R7 held request not served", {hit, 8'(beats)}, 8);

        // R1: reset mid-run clears all valid flags.
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(!cpu_stall && !cpu_rvalid, "R1 outputs after reset", {cpu_stall, cpu_rvalid}, 0);
        rst_n = 1'b1;
        access(1'b0, 14'h1AB, 16'h0, 1'b0, '0, rd, hit, sok);
        check(!hit && beats == 8, "R1 miss after reset", {hit, 8'(beats)}, 8);

        summary_and_end();
    end
endmodule